// File: doc/BRIEF.md
# Running-Disparity Word Inversion Codec

This block keeps a 67-bit serial lane DC-balanced. On the transmit side it takes 66-bit words: a 2-bit framing field and a 64-bit payload. It tracks the running disparity of everything it has sent. For each word it decides whether to send the payload as it is or inverted, and it appends a 67th bit that records that choice. On the receive side it reads that bit and restores the original 66-bit word.

Word disparity is the number of ones minus the number of zeros over all 67 transmitted bits, flag included. The transmitter inverts a word when the candidate word (flag clear, payload unchanged) has the same sign as the running disparity. When the framing field holds one one and one zero, this keeps the running disparity within ±96. An excursion output reports any time the running disparity lies outside that window, so a bench can watch the bound. Both directions register their output, which gives one clock of latency. Scrambling and framing generation happen elsewhere.

Top module: `disp_codec`

## Requirements
- R1: After the synchronous active-low reset, both output valids are low, both output words are zero, the excursion flag is low and the running disparity is zero.
- R2: Transmitted word layout: bit 66 is the inversion flag, bits 65:64 carry the input framing unchanged, and bits 63:0 carry the input payload, inverted when and only when bit 66 is 1.
- R3: The candidate disparity is 2×(ones in framing and payload) − 67, with the flag counted as 0. The word is inverted exactly when the running disparity is nonzero and has the same sign as the candidate disparity.
- R4: When the running disparity is zero, the word is sent without inversion, whatever its content.
- R5: After each accepted word, the running disparity changes by the disparity of the 67 bits actually transmitted.
- R6: For any stream whose framing is 01 or 10, the running disparity stays within ±96 and the excursion flag stays low.
- R7: The excursion flag is high exactly while the running disparity is above +96 or below −96. It changes in the same cycle as the transmitted word that moved the disparity.
- R8: The transmitter shows an accepted word on its output one clock after tx_in_valid is sampled high, and tx_out_valid follows tx_in_valid delayed by one clock.
- R9: While tx_in_valid is low, the transmit output word and the running disparity hold their values.
- R10: The receiver presents {bits 65:64, bits 63:0 XOR the flag replicated 64 times} one clock after rx_in_valid is sampled high. rx_out_valid follows rx_in_valid delayed by one clock, and the output holds while rx_in_valid is low.
- R11: A transmitted word fed to the receiver comes back identical to the 66-bit word that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_in_valid | input | 1 | Transmit input word valid |
| tx_in_word | input | 66 | Framing (65:64) and payload (63:0) to send |
| tx_out_valid | output | 1 | Transmit output word valid |
| tx_out_word | output | 67 | Flag (66), framing (65:64), payload (63:0) |
| disp_excursion | output | 1 | Running disparity outside ±96 |
| rx_in_valid | input | 1 | Receive input word valid |
| rx_in_word | input | 67 | Received 67-bit word |
| rx_out_valid | output | 1 | Receive output word valid |
| rx_out_word | output | 66 | Restored framing and payload |

## Verification
The bench targets the sign decision at its edges:
- The first word after reset is sent with zero running disparity. A design that treats zero as positive or negative would invert it.
- Candidate disparities of ±1 are applied. A design that leaves the flag out of the count, or compares with the wrong sign, would choose the wrong inversion and let the disparity drift.
- A long stream with framing 11 forces the disparity past +96. This shows whether the excursion flag rises in the correct cycle.
- A random legal stream is checked against the ±96 bound.
- Idle gaps confirm that the disparity does not move while no word is accepted.
- A round trip through the receiver catches any design that inverts the framing field or ignores the flag.

// File: rtl/disp_pkg.sv
// Package: shared widths and helpers for the disparity codec.
// Assumes the framing field sits directly above the payload and the
// inversion flag directly above the framing field.
package disp_pkg;

    localparam int PAYLOAD_W = 64;
    localparam int FRAME_W   = 2;
    localparam int IN_W      = PAYLOAD_W + FRAME_W;
    localparam int LINE_W    = IN_W + 1;
    localparam int CNT_W     = $clog2(LINE_W + 1);

    // Count the ones in a payload-sized vector.
    function automatic logic [CNT_W-1:0] ones_payload(input logic [PAYLOAD_W-1:0] v);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < PAYLOAD_W; i++) begin
            n = n + CNT_W'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/disp_meter.sv
// Module: disp_meter
// Computes, without registers, the 67-bit disparity a word would have if
// sent plain (flag 0) or inverted (flag 1). Disparity = ones - zeros.
// Assumes RD_W is wide enough to hold +/- LINE_W.
module disp_meter
    import disp_pkg::*;
#(
    parameter int RD_W = 12
) (
    input  logic [IN_W-1:0]        word,
    output logic signed [RD_W-1:0] d_plain,
    output logic signed [RD_W-1:0] d_invert
);

    logic [CNT_W-1:0] pay_ones;
    logic [CNT_W-1:0] frm_ones;

    // Purpose: count ones in the payload and in the framing field.
    always_comb begin
        pay_ones = ones_payload(word[PAYLOAD_W-1:0]);
        frm_ones = '0;
        for (int j = 0; j < FRAME_W; j++) begin
            frm_ones = frm_ones + CNT_W'(word[PAYLOAD_W + j]);
        end
    end

    logic signed [RD_W-1:0] ones_plain;
    logic signed [RD_W-1:0] ones_inv;

    // Purpose: turn ones counts of both variants into signed disparities.
    always_comb begin
        ones_plain = $signed(RD_W'(frm_ones)) + $signed(RD_W'(pay_ones));
        ones_inv   = $signed(RD_W'(frm_ones)) + $signed(RD_W'(PAYLOAD_W))
                     - $signed(RD_W'(pay_ones)) + $signed(RD_W'(1));
        d_plain    = (ones_plain <<< 1) - $signed(RD_W'(LINE_W));
        d_invert   = (ones_inv   <<< 1) - $signed(RD_W'(LINE_W));
    end

endmodule

// File: rtl/disp_tx_gen.sv
// Module: disp_tx_gen
// Transmit side: holds the running disparity and picks plain or inverted
// payload per accepted word, appending the flag as the top bit.
// Assumes the framing field holds one one and one zero for the bound to hold.
module disp_tx_gen
    import disp_pkg::*;
#(
    parameter int RD_W     = 12,
    parameter int RD_LIMIT = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_word,
    output logic              out_valid,
    output logic [LINE_W-1:0] out_word,
    output logic              excursion
);

    logic signed [RD_W-1:0] d_plain;
    logic signed [RD_W-1:0] d_invert;
    logic signed [RD_W-1:0] rd_q;
    logic                   flip;

    disp_meter #(.RD_W(RD_W)) u_meter (
        .word     (in_word),
        .d_plain  (d_plain),
        .d_invert (d_invert)
    );

    // Purpose: invert when running disparity is nonzero and shares the candidate's sign.
    always_comb begin
        flip = (rd_q != '0) && (rd_q[RD_W-1] == d_plain[RD_W-1]);
    end

    // Purpose: register output word, its valid and the running disparity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            rd_q      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word <= {flip, in_word[IN_W-1:PAYLOAD_W],
                             in_word[PAYLOAD_W-1:0] ^ {PAYLOAD_W{flip}}};
                rd_q     <= rd_q + (flip ? d_invert : d_plain);
            end
        end
    end

    // Purpose: report running disparity outside the permitted window.
    always_comb begin
        excursion = (rd_q > $signed(RD_W'(RD_LIMIT))) ||
                    (rd_q < -$signed(RD_W'(RD_LIMIT)));
    end

endmodule

// File: rtl/disp_rx_chk.sv
// Module: disp_rx_chk
// Receive side: undoes payload inversion according to the top flag bit.
// Assumes the flag is the most significant bit of the received word.
module disp_rx_chk
    import disp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [LINE_W-1:0] in_word,
    output logic              out_valid,
    output logic [IN_W-1:0]   out_word
);

    logic flag;

    // Purpose: pick out the inversion flag.
    always_comb flag = in_word[LINE_W-1];

    // Purpose: register restored word and its valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word <= {in_word[IN_W-1:PAYLOAD_W],
                             in_word[PAYLOAD_W-1:0] ^ {PAYLOAD_W{flag}}};
            end
        end
    end

endmodule

// File: rtl/disp_codec.sv
// Module: disp_codec
// Top: transmit disparity generator and receive disparity checker side by side.
// Assumes both directions share one clock and one synchronous active-low reset.
module disp_codec
    import disp_pkg::*;
#(
    parameter int RD_W     = 12,
    parameter int RD_LIMIT = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_in_valid,
    input  logic [IN_W-1:0]   tx_in_word,
    output logic              tx_out_valid,
    output logic [LINE_W-1:0] tx_out_word,
    output logic              disp_excursion,
    input  logic              rx_in_valid,
    input  logic [LINE_W-1:0] rx_in_word,
    output logic              rx_out_valid,
    output logic [IN_W-1:0]   rx_out_word
);

    disp_tx_gen #(.RD_W(RD_W), .RD_LIMIT(RD_LIMIT)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (tx_in_valid),
        .in_word   (tx_in_word),
        .out_valid (tx_out_valid),
        .out_word  (tx_out_word),
        .excursion (disp_excursion)
    );

    disp_rx_chk u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_in_valid),
        .in_word   (rx_in_word),
        .out_valid (rx_out_valid),
        .out_word  (rx_out_word)
    );

endmodule

// File: rtl/disp_codec_chk.sv
// Module: disp_codec_chk
// Port-level properties of disp_codec, attached with bind below.
module disp_codec_chk
    import disp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tx_in_valid,
    input logic [IN_W-1:0]   tx_in_word,
    input logic              tx_out_valid,
    input logic [LINE_W-1:0] tx_out_word,
    input logic              rx_in_valid,
    input logic [LINE_W-1:0] rx_in_word,
    input logic              rx_out_valid,
    input logic [IN_W-1:0]   rx_out_word
);

    AST_TX_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_in_valid |=> tx_out_valid);                                           // R8
    AST_TX_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_in_valid |=> !tx_out_valid);                                         // R8
    AST_FRAME_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_in_valid |=> tx_out_word[IN_W-1:PAYLOAD_W] == $past(tx_in_word[IN_W-1:PAYLOAD_W])); // R2
    AST_PAYLOAD_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        tx_in_valid |=> (tx_out_word[PAYLOAD_W-1:0] ^ {PAYLOAD_W{tx_out_word[LINE_W-1]}})
                        == $past(tx_in_word[PAYLOAD_W-1:0]));                    // R2
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_in_valid |=> $stable(tx_out_word));                                  // R9
    AST_RX_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_in_valid |=> rx_out_valid && rx_out_word ==
            {$past(rx_in_word[IN_W-1:PAYLOAD_W]),
             $past(rx_in_word[PAYLOAD_W-1:0]) ^ {PAYLOAD_W{$past(rx_in_word[LINE_W-1])}}}); // R10
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_in_valid |=> !rx_out_valid && $stable(rx_out_word));                 // R10

endmodule

bind disp_codec disp_codec_chk u_disp_codec_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_in_valid  (tx_in_valid),
    .tx_in_word   (tx_in_word),
    .tx_out_valid (tx_out_valid),
    .tx_out_word  (tx_out_word),
    .rx_in_valid  (rx_in_valid),
    .rx_in_word   (rx_in_word),
    .rx_out_valid (rx_out_valid),
    .rx_out_word  (rx_out_word)
);

// File: tb/disp_codec_bench.sv
module disp_codec_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_in_valid = 1'b0;
    logic [65:0] tx_in_word = '0;
    logic        tx_out_valid;
    logic [66:0] tx_out_word;
    logic        disp_excursion;
    logic        rx_in_valid = 1'b0;
    logic [66:0] rx_in_word = '0;
    logic        rx_out_valid;
    logic [65:0] rx_out_word;

    int n_vec  = 0;
    int n_miss = 0;
    int m_rd   = 0;
    int max_abs_rd = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    disp_codec u_disp_codec (
        .clk(clk), .rst_n(rst_n),
        .tx_in_valid(tx_in_valid), .tx_in_word(tx_in_word),
        .tx_out_valid(tx_out_valid), .tx_out_word(tx_out_word),
        .disp_excursion(disp_excursion),
        .rx_in_valid(rx_in_valid), .rx_in_word(rx_in_word),
        .rx_out_valid(rx_out_valid), .rx_out_word(rx_out_word)
    );

    task automatic check(input string req, input logic [66:0] act, input logic [66:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ones(input logic [66:0] v);
        int n = 0;
        for (int i = 0; i < 67; i++) n += int'(v[i]);
        return n;
    endfunction

    // Reference model step: returns expected 67-bit line word and updates m_rd.
    function automatic logic [66:0] model_tx(input logic [65:0] w);
        int d0;
        bit inv;
        logic [66:0] o;
        d0  = 2 * ones({1'b0, w}) - 67;
        inv = (m_rd != 0) && ((m_rd > 0) == (d0 > 0));
        o   = {inv, w[65:64], w[63:0] ^ {64{inv}}};
        m_rd += 2 * ones(o) - 67;
        if (m_rd > max_abs_rd) max_abs_rd = m_rd;
        if (-m_rd > max_abs_rd) max_abs_rd = -m_rd;
        return o;
    endfunction

    // Called at a negedge; leaves at the next negedge after checking.
    task automatic tx_step(input logic [65:0] w, input string req, output logic [66:0] got);
        logic [66:0] exp;
        tx_in_valid = 1'b1;
        tx_in_word  = w;
        exp = model_tx(w);
        @(negedge clk);
        got = tx_out_word;
        check({req, " tx word"}, tx_out_word, exp);
        check("R8 tx valid", {66'b0, tx_out_valid}, 67'd1);
        check("R7 excursion", {66'b0, disp_excursion}, {66'b0, (m_rd > 96 || m_rd < -96)});
    endtask

    task automatic rx_step(input logic [66:0] w, input logic [65:0] exp, input string req);
        rx_in_valid = 1'b1;
        rx_in_word  = w;
        @(negedge clk);
        check({req, " rx word"}, {1'b0, rx_out_word}, {1'b0, exp});
        check("R10 rx valid", {66'b0, rx_out_valid}, 67'd1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tx_in_valid = 1'b0; rx_in_valid = 1'b0;
        m_rd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 tx valid", {66'b0, tx_out_valid}, 67'd0);
        check("R1 tx word", tx_out_word, 67'd0);
        check("R1 excursion", {66'b0, disp_excursion}, 67'd0);
        check("R1 rx valid", {66'b0, rx_out_valid}, 67'd0);
        check("R1 rx word", {1'b0, rx_out_word}, 67'd0);
    endtask

    // First word with zero disparity is never inverted; then the sign rule.
    task automatic t_sign_rule();
        logic [66:0] g;
        do_reset();
        tx_step({2'b01, {64{1'b1}}}, "R4", g);
        check("R4 no flip at rd 0", {66'b0, g[66]}, 67'd0);
        tx_step({2'b10, {64{1'b1}}}, "R3", g);
        check("R3 flip on same sign", {66'b0, g[66]}, 67'd1);
        tx_step({2'b01, 32'h0, 32'hFFFF_FFFF}, "R3", g);   // candidate -1
        tx_step({2'b10, 31'h0, 33'h1_FFFF_FFFF}, "R3", g);  // candidate +1
        tx_step({2'b01, 64'h0}, "R5", g);
        tx_step({2'b10, 64'h0}, "R5", g);
        tx_in_valid = 1'b0;
    endtask

    // Idle cycles: output and disparity hold, shown by next decision.
    task automatic t_hold();
        logic [66:0] g, held;
        do_reset();
        tx_step({2'b01, {64{1'b1}}}, "R9", g);
        held = g;
        tx_in_valid = 1'b0;
        tx_in_word  = {2'b10, 64'h1234_5678_9ABC_DEF0};
        repeat (4) @(negedge clk);
        check("R9 hold word", tx_out_word, held);
        check("R8 idle valid", {66'b0, tx_out_valid}, 67'd0);
        tx_step({2'b10, 64'hFFFF_FFFF_0000_FFFF}, "R9", g);
        tx_in_valid = 1'b0;
    endtask

    task automatic t_random_loop();
        logic [66:0] g;
        logic [65:0] w;
        do_reset();
        max_abs_rd = 0;
        for (int k = 0; k < 300; k++) begin
            w = {($urandom % 2) ? 2'b01 : 2'b10, $urandom(), $urandom()};
            if (k % 7 == 0) w[63:0] = {64{w[0]}};
            tx_step(w, "R5", g);
            tx_in_valid = 1'b0;
            rx_step(g, w, "R11");
            rx_in_valid = 1'b0;
            if (k % 5 == 0) @(negedge clk);
        end
        check("R6 bound held", {66'b0, max_abs_rd <= 96}, 67'd1);
        check("R6 excursion low", {66'b0, disp_excursion}, 67'd0);
    endtask

    task automatic t_rx_direct();
        do_reset();
        rx_step({1'b0, 2'b11, 64'h0F0F_0000_FFFF_1234}, {2'b11, 64'h0F0F_0000_FFFF_1234}, "R10");
        rx_step({1'b1, 2'b00, 64'h0F0F_0000_FFFF_1234}, {2'b00, 64'hF0F0_FFFF_0000_EDCB}, "R10");
        rx_in_valid = 1'b0;
        rx_in_word = '1;
        repeat (2) @(negedge clk);
        check("R10 rx hold", {1'b0, rx_out_word}, {1'b0, 2'b00, 64'hF0F0_FFFF_0000_EDCB});
        check("R10 rx idle valid", {66'b0, rx_out_valid}, 67'd0);
    endtask

    // Illegal framing 11 with 32 payload ones drives disparity past +96.
    task automatic t_excursion();
        logic [66:0] g;
        bit seen = 1'b0;
        do_reset();
        for (int k = 0; k < 40; k++) begin
            tx_step({2'b11, 32'h0, 32'hFFFF_FFFF}, "R7", g);
            if (disp_excursion) seen = 1'b1;
        end
        tx_in_valid = 1'b0;
        check("R7 excursion reached", {66'b0, seen}, 67'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_sign_rule();
        t_hold();
        t_rx_direct();
        t_random_loop();
        t_excursion();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule